// File: doc/BRIEF.md
# Microcode Store Parity Retry and Spare Remapping

This block sits between a microsequencer and a reloadable microcode store. Every word read from the store carries an even-parity bit, and the block checks it in the cycle the word returns. A clean word goes straight to the microsequencer. A failing word causes one retry read of the same location in the next cycle. If the retry also fails, the address is treated as permanently bad. It is written into the next free entry of a small remap table, and a loader port is asked to fill the matching spare slot with a fresh copy of the microcode. When the loader reports completion, the original read is issued again, this time from the spare slot.

The remap table is compared against every request address in the same cycle as the request. A remapped address is therefore served from its spare slot with the same one-cycle latency as any other address. Only eight spare slots exist. A further uncorrectable address, or a failure that persists on a spare slot across its retry, halts the block. The halt sets a sticky repair-required flag, which only reset clears.

The controller has six states. RUN accepts requests and checks returning words. RETRY_RD reissues a failed read. CHECK judges a retried or refetched word. RELOAD waits for the loader. REFETCH reads the new spare slot. HALT is terminal. The transitions are:
- RUN to RETRY_RD on a parity error.
- RETRY_RD to CHECK.
- CHECK to RUN on clean data.
- CHECK to RELOAD on a second error with a slot free.
- CHECK to HALT on a second error that was a spare read, or when all slots are used.
- RELOAD to REFETCH on loader done.
- REFETCH to CHECK.

Top module: `cs_spare_remap`

## Requirements
- R1: A request accepted while stall is low is read from the store in the same cycle. If the returned word has even parity (data bits and parity bit XOR to 0), rsp_valid is high with that word in the next cycle. A new request can be accepted in that same cycle, so clean reads stream at one per cycle.
- R2: On a parity error in a returning word, stall is high in that cycle. Exactly one retry read of the same address is issued in the next cycle. If the retry word is clean, it is returned two cycles after the error cycle, and used_cnt is unchanged.
- R3: If the retry also fails on a main-store address, that address is written into the table entry whose index equals used_cnt, and used_cnt increments by one. remap_pulse is high for one cycle. ld_req stays high with ld_addr set to the failing address and ld_slot set to the entry index until ld_done.
- R4: In the cycle after ld_done, the read is reissued from the spare slot. Its word is returned in the following cycle. With a loader that answers four cycles after ld_req rises, a remapping read therefore completes ten cycles after acceptance.
- R5: Any later request for a remapped address drives st_spare=1 and st_slot set to its entry. It returns the spare word with the one-cycle latency of R1.
- R6: used_cnt never exceeds 8. An uncorrectable main-store error with all 8 slots used allocates nothing and enters HALT, so fatal is high two cycles after the failing retry read is issued.
- R7: A spare-slot read that fails both its first read and its retry enters HALT. The block does not allocate another slot for it.
- R8: In HALT, fatal and stall stay high, no store read is issued and rsp_valid stays low, whatever the requests, until reset.
- R9: Reset clears every table entry and used_cnt, and returns the controller to RUN with stall, fatal, ld_req and rsp_valid low. After reset, a previously remapped address is read from the main store again.
- R10: While stall is high, no new request is accepted. A request held across a retry is accepted in the first cycle with stall low and answered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Microsequencer read request |
| req_addr | input | AW | Requested microcode address |
| rsp_valid | output | 1 | Returned word is valid this cycle |
| rsp_data | output | DW | Returned microcode word |
| stall | output | 1 | Requests are not accepted this cycle |
| st_rd_en | output | 1 | Store read strobe |
| st_addr | output | AW | Store main-array address |
| st_spare | output | 1 | Read targets the spare area |
| st_slot | output | $clog2(SLOTS) | Spare slot index |
| st_data | input | DW | Store word, one cycle after st_rd_en |
| st_par | input | 1 | Even-parity bit of st_data |
| ld_req | output | 1 | Spare slot awaits loading |
| ld_addr | output | AW | Address whose microcode must be loaded |
| ld_slot | output | $clog2(SLOTS) | Spare slot to load |
| ld_done | input | 1 | Loader finished the slot |
| remap_pulse | output | 1 | One-cycle pulse on each new remap |
| fatal | output | 1 | Sticky repair-required halt |
| used_cnt | output | $clog2(SLOTS+1) | Number of spare slots in use |

## Verification
The properties rely on two input rules. The store returns the word for a strobe exactly one cycle later, and ld_done is only raised while ld_req is high. The retry-address and response-follows-read checks are only meaningful under these rules. The bench store model answers every strobe on the next edge. The loader model counts cycles only while ld_req is high, pulses ld_done once, and clears its count as soon as the request drops. Faults are injected only through per-address transient counts, per-address permanent flags and per-slot spare flags. The stimulus therefore never breaks the parity or timing contract except at the points where a fault is meant to occur.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [2:0] {
        S_RUN,
        S_RETRY_RD,
        S_CHECK,
        S_RELOAD,
        S_REFETCH,
        S_HALT
    } csr_state_t;

endpackage

// File: rtl/csr_parity.sv
module csr_parity #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    output logic          err
);

    // Even parity: a good word has an even number of ones including the parity bit.
    assign err = ^{data, par};

endmodule

// File: rtl/csr_remap_table.sv
module csr_remap_table #(
    parameter  int AW    = 8,
    parameter  int SLOTS = 8,
    localparam int IW    = $clog2(SLOTS),
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    input  logic          alloc_en,
    input  logic [AW-1:0] alloc_addr,
    output logic [CW-1:0] used,
    output logic [IW-1:0] free_idx,
    output logic          full
);

    logic [SLOTS-1:0] ent_hit;

    assign full     = (used == CW'(SLOTS));
    assign free_idx = IW'(used);

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_entry
        logic          v_q;
        logic [AW-1:0] a_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                a_q <= '0;
            end else if (alloc_en && !full && (used == CW'(gi))) begin
                v_q <= 1'b1;
                a_q <= alloc_addr;
            end
        end

        assign ent_hit[gi] = v_q && (a_q == lk_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (alloc_en && !full) begin
            used <= used + CW'(1);
        end
    end

    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (ent_hit[i]) begin
                lk_idx = IW'(i);
            end
        end
    end

    assign lk_hit = |ent_hit;

endmodule

// File: rtl/csr_ctrl.sv
module csr_ctrl
    import csr_pkg::*;
#(
    parameter  int AW    = 8,
    parameter  int SLOTS = 8,
    localparam int IW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          lk_hit,
    input  logic [IW-1:0] lk_idx,
    input  logic          par_err,
    input  logic          full,
    input  logic [IW-1:0] free_idx,
    input  logic          ld_done,
    output logic          st_rd_en,
    output logic [AW-1:0] st_addr,
    output logic          st_spare,
    output logic [IW-1:0] st_slot,
    output logic          rsp_valid,
    output logic          stall,
    output logic          alloc_en,
    output logic [AW-1:0] alloc_addr,
    output logic          ld_req,
    output logic [AW-1:0] ld_addr,
    output logic [IW-1:0] ld_slot,
    output logic          remap_pulse,
    output logic          fatal,
    output logic          data_pending,
    output csr_state_t    state
);

    csr_state_t    nxt;
    logic          accept;
    logic [AW-1:0] sv_addr;
    logic          sv_spare;
    logic [IW-1:0] sv_slot;
    logic          remap_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_RUN;
        end else begin
            state <= nxt;
        end
    end

    // Saved read context and pulse flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_pending <= 1'b0;
            sv_addr      <= '0;
            sv_spare     <= 1'b0;
            sv_slot      <= '0;
            remap_q      <= 1'b0;
        end else begin
            data_pending <= (state == S_RUN) && accept;
            remap_q      <= alloc_en;
            if ((state == S_RUN) && accept) begin
                sv_addr  <= req_addr;
                sv_spare <= lk_hit;
                sv_slot  <= lk_idx;
            end else if (alloc_en) begin
                sv_spare <= 1'b1;
                sv_slot  <= free_idx;
            end
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN:      if (data_pending && par_err) nxt = S_RETRY_RD;
            S_RETRY_RD: nxt = S_CHECK;
            S_CHECK: begin
                if (!par_err)                nxt = S_RUN;
                else if (sv_spare || full)   nxt = S_HALT;
                else                         nxt = S_RELOAD;
            end
            S_RELOAD:   if (ld_done) nxt = S_REFETCH;
            S_REFETCH:  nxt = S_CHECK;
            S_HALT:     nxt = S_HALT;
            default:    nxt = S_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        accept     = 1'b0;
        st_rd_en   = 1'b0;
        st_addr    = sv_addr;
        st_spare   = sv_spare;
        st_slot    = sv_slot;
        rsp_valid  = 1'b0;
        stall      = 1'b1;
        alloc_en   = 1'b0;
        alloc_addr = sv_addr;
        ld_req     = 1'b0;
        ld_addr    = sv_addr;
        ld_slot    = sv_slot;
        fatal      = 1'b0;
        unique case (state)
            S_RUN: begin
                stall     = data_pending && par_err;
                accept    = req_valid && !stall;
                st_rd_en  = accept;
                st_addr   = req_addr;
                st_spare  = lk_hit;
                st_slot   = lk_idx;
                rsp_valid = data_pending && !par_err;
            end
            S_RETRY_RD, S_REFETCH: begin
                st_rd_en = 1'b1;
            end
            S_CHECK: begin
                rsp_valid = !par_err;
                alloc_en  = par_err && !sv_spare && !full;
            end
            S_RELOAD: begin
                ld_req = 1'b1;
            end
            S_HALT: begin
                fatal = 1'b1;
            end
            default: begin
                fatal = 1'b1;
            end
        endcase
    end

    assign remap_pulse = remap_q;

endmodule

// File: rtl/cs_spare_remap.sv
module cs_spare_remap #(
    parameter  int AW    = 8,
    parameter  int DW    = 16,
    parameter  int SLOTS = 8,
    localparam int IW    = $clog2(SLOTS),
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          stall,
    output logic          st_rd_en,
    output logic [AW-1:0] st_addr,
    output logic          st_spare,
    output logic [IW-1:0] st_slot,
    input  logic [DW-1:0] st_data,
    input  logic          st_par,
    output logic          ld_req,
    output logic [AW-1:0] ld_addr,
    output logic [IW-1:0] ld_slot,
    input  logic          ld_done,
    output logic          remap_pulse,
    output logic          fatal,
    output logic [CW-1:0] used_cnt
);

    logic                 par_err;
    logic                 lk_hit;
    logic [IW-1:0]        lk_idx;
    logic                 tbl_full;
    logic [IW-1:0]        free_idx;
    logic                 alloc_en;
    logic [AW-1:0]        alloc_addr;
    logic                 data_pending;
    csr_pkg::csr_state_t  ctl_state;

    csr_parity #(.DW(DW)) u_par (
        .data (st_data),
        .par  (st_par),
        .err  (par_err)
    );

    csr_remap_table #(.AW(AW), .SLOTS(SLOTS)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (req_addr),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .alloc_en   (alloc_en),
        .alloc_addr (alloc_addr),
        .used       (used_cnt),
        .free_idx   (free_idx),
        .full       (tbl_full)
    );

    csr_ctrl #(.AW(AW), .SLOTS(SLOTS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .lk_hit       (lk_hit),
        .lk_idx       (lk_idx),
        .par_err      (par_err),
        .full         (tbl_full),
        .free_idx     (free_idx),
        .ld_done      (ld_done),
        .st_rd_en     (st_rd_en),
        .st_addr      (st_addr),
        .st_spare     (st_spare),
        .st_slot      (st_slot),
        .rsp_valid    (rsp_valid),
        .stall        (stall),
        .alloc_en     (alloc_en),
        .alloc_addr   (alloc_addr),
        .ld_req       (ld_req),
        .ld_addr      (ld_addr),
        .ld_slot      (ld_slot),
        .remap_pulse  (remap_pulse),
        .fatal        (fatal),
        .data_pending (data_pending),
        .state        (ctl_state)
    );

    assign rsp_data = st_data;

endmodule

// File: rtl/csr_checker.sv
module csr_checker
    import csr_pkg::*;
#(
    parameter int AW    = 8,
    parameter int SLOTS = 8,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input csr_state_t    state,
    input logic          data_pending,
    input logic          par_err,
    input logic          st_rd_en,
    input logic [AW-1:0] st_addr,
    input logic          stall,
    input logic          rsp_valid,
    input logic          fatal,
    input logic [CW-1:0] used_cnt,
    input logic          ld_req,
    input logic          ld_done,
    input logic [AW-1:0] ld_addr,
    input logic [IW-1:0] ld_slot,
    input logic          remap_pulse
);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(st_rd_en)); // R1

    AST_RETRY_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && data_pending && par_err) |=> (st_rd_en && st_addr == $past(st_addr, 2))); // R2

    AST_USED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(used_cnt) |-> (used_cnt == $past(used_cnt) + CW'(1))); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |=> !remap_pulse); // R3

    AST_PULSE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |-> (CW'(ld_slot) + CW'(1) == used_cnt)); // R3

    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_done) |=> (ld_req && $stable(ld_addr) && $stable(ld_slot))); // R3

    AST_USED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt <= CW'(SLOTS)); // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal); // R8

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> (stall && !st_rd_en && !rsp_valid)); // R8

endmodule

bind cs_spare_remap csr_checker #(.AW(AW), .SLOTS(SLOTS), .IW(IW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (ctl_state),
    .data_pending (data_pending),
    .par_err      (par_err),
    .st_rd_en     (st_rd_en),
    .st_addr      (st_addr),
    .stall        (stall),
    .rsp_valid    (rsp_valid),
    .fatal        (fatal),
    .used_cnt     (used_cnt),
    .ld_req       (ld_req),
    .ld_done      (ld_done),
    .ld_addr      (ld_addr),
    .ld_slot      (ld_slot),
    .remap_pulse  (remap_pulse)
);

// File: tb/cs_spare_remap_bench.sv
`timescale 1ns/1ps
module cs_spare_remap_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        stall;
    logic        st_rd_en;
    logic [7:0]  st_addr;
    logic        st_spare;
    logic [2:0]  st_slot;
    logic [15:0] st_data = '0;
    logic        st_par = 1'b0;
    logic        ld_req;
    logic [7:0]  ld_addr;
    logic [2:0]  ld_slot;
    logic        ld_done = 1'b0;
    logic        remap_pulse;
    logic        fatal;
    logic [3:0]  used_cnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int   trans   [256];
    bit   perm    [256];
    int   rd_cnt  [256];
    logic [15:0] spare_mem [8];
    bit   spare_bad [8];
    int   total_rd = 0;
    logic last_spare = 1'b0;
    logic [2:0] last_slot = '0;
    logic [15:0] mv;
    logic mbad;
    int   ld_cnt = 0;

    always #2.5 clk = ~clk;

    cs_spare_remap u_cs_spare_remap (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .stall(stall),
        .st_rd_en(st_rd_en), .st_addr(st_addr), .st_spare(st_spare), .st_slot(st_slot),
        .st_data(st_data), .st_par(st_par), .ld_req(ld_req), .ld_addr(ld_addr),
        .ld_slot(ld_slot), .ld_done(ld_done), .remap_pulse(remap_pulse),
        .fatal(fatal), .used_cnt(used_cnt)
    );

    function automatic logic [15:0] golden(input logic [7:0] a);
        return 16'(a) * 16'd97 + 16'd13;
    endfunction

    // Store model: one-cycle read latency, even parity, injectable faults
    always @(posedge clk) begin
        if (st_rd_en) begin
            if (st_spare) begin
                mv   = spare_mem[st_slot];
                mbad = spare_bad[st_slot];
            end else begin
                mv   = golden(st_addr);
                mbad = perm[st_addr] || (trans[st_addr] > 0);
                if (trans[st_addr] > 0) trans[st_addr] = trans[st_addr] - 1;
                rd_cnt[st_addr] = rd_cnt[st_addr] + 1;
            end
            total_rd   = total_rd + 1;
            last_spare <= st_spare;
            last_slot  <= st_slot;
            st_data    <= mv;
            st_par     <= (^mv) ^ mbad;
        end
    end

    // Loader model: answers four cycles after ld_req rises
    always @(posedge clk) begin
        if (!ld_req) begin
            ld_cnt  <= 0;
            ld_done <= 1'b0;
        end else if (ld_done) begin
            ld_cnt  <= 0;
            ld_done <= 1'b0;
        end else if (ld_cnt == 3) begin
            spare_mem[ld_slot] <= golden(ld_addr);
            ld_done <= 1'b1;
        end else begin
            ld_cnt <= ld_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issues one request at a negedge; returns at the negedge where the result is seen.
    task automatic do_read(input logic [7:0] a, input int exp_lat, input bit exp_fatal,
                           input string rq, output int pulses, output bit lds,
                           output logic [7:0] la, output logic [2:0] ls);
        int lat;
        logic [15:0] got;
        lat = -1; got = '0; pulses = 0; lds = 0; la = '0; ls = '0;
        while (stall && !fatal) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        for (int c = 1; c <= 30; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (remap_pulse) pulses++;
            if (ld_req) begin lds = 1; la = ld_addr; ls = ld_slot; end
            if (exp_fatal && fatal && lat < 0) lat = c;
            if (!exp_fatal && rsp_valid && lat < 0) begin lat = c; got = rsp_data; end
            if (lat >= 0) break;
        end
        chk(lat == exp_lat, rq, "latency", lat, exp_lat);
        if (!exp_fatal) chk(got == golden(a), rq, "data", got, golden(a));
    endtask

    logic [7:0] rmap [8];

    initial begin
        int p; bit ls_seen; logic [7:0] la; logic [2:0] ls;
        int b40, b41, t0;
        for (int i = 0; i < 256; i++) begin trans[i] = 0; perm[i] = 0; rd_cnt[i] = 0; end
        for (int i = 0; i < 8; i++) begin spare_mem[i] = '0; spare_bad[i] = 0; rmap[i] = 8'(i * 29 + 7); end

        do_reset();
        // R9 reset state
        chk(!stall && !fatal && !ld_req && !rsp_valid, "R9", "idle outputs", {stall, fatal, ld_req, rsp_valid}, 0);
        chk(used_cnt == 0, "R9", "used_cnt after reset", used_cnt, 0);

        // R1 clean sweep over every address
        for (int a = 0; a < 256; a++) begin
            do_read(8'(a), 1, 0, "R1", p, ls_seen, la, ls);
        end

        // R1 streaming: one request per cycle
        req_valid = 1'b1; req_addr = 8'd200;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_data == golden(8'(200 + k - 1)), "R1", "stream word",
                rsp_data, golden(8'(200 + k - 1)));
            if (k < 16) req_addr = 8'(200 + k); else req_valid = 1'b0;
        end
        @(negedge clk);

        // R2 transient errors: retried once, no remap
        for (int a = 100; a < 116; a++) begin
            trans[a] = 1;
            do_read(8'(a), 3, 0, "R2", p, ls_seen, la, ls);
            chk(p == 0 && !ls_seen, "R2", "no remap activity", p, 0);
        end
        chk(used_cnt == 0, "R2", "used_cnt unchanged", used_cnt, 0);

        // R10 / R2: request held across a retry
        @(negedge clk);
        b40 = rd_cnt[40]; b41 = rd_cnt[41];
        trans[40] = 1;
        req_valid = 1'b1; req_addr = 8'd40;
        @(negedge clk);
        chk(stall == 1, "R10", "stall on error cycle", stall, 1);
        req_addr = 8'd41;
        @(negedge clk);
        chk(stall == 1, "R10", "stall during retry", stall, 1);
        @(negedge clk);
        chk(rsp_valid && rsp_data == golden(8'd40), "R2", "retry word", rsp_data, golden(8'd40));
        @(negedge clk);
        chk(stall == 0, "R10", "stall released", stall, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_data == golden(8'd41), "R10", "held request answered", rsp_data, golden(8'd41));
        chk(rd_cnt[40] - b40 == 2, "R2", "reads of failing address", rd_cnt[40] - b40, 2);
        chk(rd_cnt[41] - b41 == 1, "R10", "held request read once", rd_cnt[41] - b41, 1);
        @(negedge clk);

        // R3 / R4: permanent faults fill all eight slots
        for (int i = 0; i < 8; i++) begin
            perm[rmap[i]] = 1;
            do_read(rmap[i], 10, 0, "R4", p, ls_seen, la, ls);
            chk(p == 1, "R3", "remap pulse count", p, 1);
            chk(ls_seen && la == rmap[i], "R3", "loader address", la, rmap[i]);
            chk(ls == 3'(i), "R3", "loader slot", ls, i);
            chk(used_cnt == 4'(i + 1), "R3", "used_cnt", used_cnt, i + 1);
        end

        // R5: remapped addresses served from spare at full speed
        for (int i = 0; i < 8; i++) begin
            do_read(rmap[i], 1, 0, "R5", p, ls_seen, la, ls);
            chk(last_spare == 1 && last_slot == 3'(i), "R5", "spare slot used", last_slot, i);
        end

        // R2 still works when the table is full
        trans[3] = 1;
        do_read(8'd3, 3, 0, "R2", p, ls_seen, la, ls);
        chk(used_cnt == 8, "R6", "used_cnt saturated", used_cnt, 8);

        // R6: ninth uncorrectable address halts
        perm[8'd250] = 1;
        do_read(8'd250, 4, 1, "R6", p, ls_seen, la, ls);
        chk(p == 0 && !ls_seen, "R6", "no ninth allocation", p, 0);
        chk(used_cnt == 8, "R6", "used_cnt capped", used_cnt, 8);

        // R8: halt is sticky and quiet
        t0 = total_rd;
        req_valid = 1'b1; req_addr = 8'd5;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(fatal && stall && !rsp_valid, "R8", "halt outputs", {fatal, stall, rsp_valid}, 6);
        end
        req_valid = 1'b0;
        chk(total_rd == t0, "R8", "no store reads in halt", total_rd - t0, 0);

        // R9: reset clears the table; remapped address goes to main store again
        do_reset();
        chk(!fatal && !stall && used_cnt == 0, "R9", "cleared after halt", used_cnt, 0);
        do_read(rmap[0], 10, 0, "R9", p, ls_seen, la, ls);
        chk(ls == 3'd0 && used_cnt == 1, "R9", "realloc into slot 0", ls, 0);

        // R7: failing spare slot is fatal after its retry
        spare_bad[0] = 1;
        do_read(rmap[0], 4, 1, "R7", p, ls_seen, la, ls);
        chk(used_cnt == 1 && p == 0, "R7", "no extra allocation", used_cnt, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule